// File: doc/BRIEF.md
# Custom-Instruction Execution Sequencer

This block runs one multi-cycle custom instruction next to a base pipeline. A local table holds one record per custom instruction. A record gives the source register indices, the destination register indices with their valid bits, the execution latency, and an opaque field that goes to the reconfigurable matrix unchanged. A start pulse with an entry number plays the role of the coprocessor-move write that launches the instruction. That start pulse copies the chosen record into a working register.

The sequencer then steps three counters through three phases. First it issues source indices on the register-file read ports, four per cycle. Next it waits out the latency while the matrix computes. Last it issues destination indices on the write ports, four per cycle, and enables only the valid ones. During the whole run it stalls the pipeline and selects the matrix as the result source. One cycle after the last write-back beat it raises a done pulse and hands the result path back to the normal units.

Top module: `cix_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, stall, res_sel, done, err and every bit of rd_en and wr_en are 0.
- R2: A record is written into entry cfg_addr through cfg_we/cfg_wdata only while stall is low; a write while stall is high leaves the entry unchanged. The record layout is: bits [3:0] source count (0..8); source i at [4+5i +: 5]; destination valid bits at [49:44] (bit j for destination j); destination j at [50+5j +: 5]; latency at [82:80]; opaque matrix field at [98:83].
- R3: A trig pulse sampled while stall is low starts a run on entry trig_sel; stall is high for exactly R+L+W cycles beginning the cycle after that edge (R read beats, L latency cycles, W write beats).
- R4: In read beat b, read port p carries source index b*4+p, and it is enabled only when that index is below the source count; R = ceil(count/4), at least 1 and at most 2.
- R5: The latency phase lasts L cycles with no read or write enables; a latency field of 0 is taken as 1 and a value above 5 as 5.
- R6: In write beat b, write port p carries destination b*4+p, and it is enabled only when that destination's valid bit is set; W is (highest valid index)/4 + 1, and 1 when no bit is set.
- R7: res_sel is high in exactly the cycles in which stall is high.
- R8: done is high for one cycle, the cycle right after the last write beat, with stall low; a trig in that cycle starts a new run.
- R9: A trig sampled while stall is high does not change the running sequence, and err is high for exactly the next cycle.
- R10: While stall is high, mcfg equals the opaque field of the entry selected at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Record write enable |
| cfg_addr | input | 4 | Record entry to write |
| cfg_wdata | input | 99 | Record contents |
| trig | input | 1 | Start pulse |
| trig_sel | input | 4 | Entry to execute |
| stall | output | 1 | Pipeline hold while a run is in progress |
| res_sel | output | 1 | 1 selects the matrix result, 0 the normal units |
| rd_en | output | 4 | Read-port enables |
| rd_addr | output | 20 | Read-port register indices, port p at [5p +: 5] |
| wr_en | output | 4 | Write-port enables |
| wr_addr | output | 20 | Write-port register indices, port p at [5p +: 5] |
| mcfg | output | 16 | Opaque matrix configuration of the running entry |
| done | output | 1 | End-of-run pulse |
| err | output | 1 | Pulse for a start that was ignored |

## Verification
The hardest case to reach is a collision: a second start and a table write that both arrive in the middle of a run, and aimed at the entry that is running. The stimulus raises both in the second read beat of a nine-cycle run. It checks that the error pulse appears in the next cycle and that every port beat still matches the original record. It then runs the same entry again to show that the write was dropped. Starting a new run in the done cycle checks the edge at the end of a run.

// File: rtl/cix_pkg.sv
package cix_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_READ = 2'd1,
      PH_EXEC = 2'd2,
      PH_WB   = 2'd3
   } cix_phase_e;
endpackage

// File: rtl/cix_cfg_mem.sv
module cix_cfg_mem #(
   parameter int DEPTH = 16,
   parameter int RECW  = 99,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic            lock,
   input  logic [AW-1:0]   waddr,
   input  logic [RECW-1:0] wdata,
   input  logic [AW-1:0]   raddr,
   output logic [RECW-1:0] rdata
);
   logic [RECW-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_chk_depth
      $error("cix_cfg_mem: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (we && !lock) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   // R2
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lock) |=> (mem[$past(waddr)] == $past(mem[waddr])));
endmodule

// File: rtl/cix_seq_fsm.sv
module cix_seq_fsm
   import cix_pkg::*;
#(
   parameter int RBW    = 1,
   parameter int WBW    = 1,
   parameter int LATW   = 3,
   parameter int MAXLAT = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [RBW:0]    n_rd,
   input  logic [LATW-1:0] n_lat,
   input  logic [WBW:0]    n_wb,
   output cix_phase_e      phase,
   output logic [RBW-1:0]  rd_beat,
   output logic [WBW-1:0]  wr_beat,
   output logic            done
);
   logic [LATW-1:0] lat_ctr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         rd_beat <= '0;
         wr_beat <= '0;
         lat_ctr <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) begin
               phase   <= PH_READ;
               rd_beat <= '0;
            end
            PH_READ: if ({1'b0, rd_beat} + 1'b1 >= n_rd) begin
               phase   <= PH_EXEC;
               lat_ctr <= LATW'(1);
            end else begin
               rd_beat <= rd_beat + 1'b1;
            end
            PH_EXEC: if (lat_ctr >= n_lat) begin
               phase   <= PH_WB;
               wr_beat <= '0;
            end else begin
               lat_ctr <= lat_ctr + 1'b1;
            end
            PH_WB: if ({1'b0, wr_beat} + 1'b1 >= n_wb) begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end else begin
               wr_beat <= wr_beat + 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R5
   lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC) |-> (lat_ctr <= LATW'(MAXLAT)));
endmodule

// File: rtl/cix_port_map.sv
module cix_port_map #(
   parameter int NPORT = 4,
   parameter int NIDX  = 8,
   parameter int RW    = 5,
   parameter int BW    = 1
) (
   input  logic              active,
   input  logic [BW-1:0]     beat,
   input  logic [NIDX-1:0]   idx_en,
   input  logic [NIDX*RW-1:0] idx_reg,
   output logic [NPORT-1:0]  port_en,
   output logic [NPORT*RW-1:0] port_reg
);
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_comb begin
         int slot;
         slot = int'(beat) * NPORT + p;
         port_en[p]            = 1'b0;
         port_reg[p*RW +: RW]  = '0;
         for (int i = 0; i < NIDX; i++) begin
            if (i == slot) begin
               port_en[p]           = active & idx_en[i];
               port_reg[p*RW +: RW] = idx_reg[i*RW +: RW];
            end
         end
      end
   end
endmodule

// File: rtl/cix_sequencer.sv
module cix_sequencer
   import cix_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int NSRC   = 8,
   parameter int NDST   = 6,
   parameter int RP     = 4,
   parameter int WP     = 4,
   parameter int RW     = 5,
   parameter int MAXLAT = 5,
   parameter int CFGW   = 16,
   localparam int AW      = $clog2(DEPTH),
   localparam int SCW     = $clog2(NSRC + 1),
   localparam int LATW    = $clog2(MAXLAT + 1),
   localparam int OFF_SRC = SCW,
   localparam int OFF_VLD = OFF_SRC + NSRC * RW,
   localparam int OFF_DST = OFF_VLD + NDST,
   localparam int OFF_LAT = OFF_DST + NDST * RW,
   localparam int OFF_OP  = OFF_LAT + LATW,
   localparam int RECW    = OFF_OP + CFGW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [RECW-1:0]   cfg_wdata,
   input  logic              trig,
   input  logic [AW-1:0]     trig_sel,
   output logic              stall,
   output logic              res_sel,
   output logic [RP-1:0]     rd_en,
   output logic [RP*RW-1:0]  rd_addr,
   output logic [WP-1:0]     wr_en,
   output logic [WP*RW-1:0]  wr_addr,
   output logic [CFGW-1:0]   mcfg,
   output logic              done,
   output logic              err
);
   localparam int NRB = (NSRC + RP - 1) / RP;
   localparam int NWB = (NDST + WP - 1) / WP;
   localparam int RBW = (NRB > 1) ? $clog2(NRB) : 1;
   localparam int WBW = (NWB > 1) ? $clog2(NWB) : 1;

   if (RP < 1 || WP < 1) begin : g_chk_ports
      $error("cix_sequencer: port counts must be at least 1");
   end
   if (MAXLAT < 1 || NSRC < 1 || NDST < 1) begin : g_chk_sizes
      $error("cix_sequencer: MAXLAT, NSRC and NDST must be at least 1");
   end

   cix_phase_e      phase;
   logic            busy, start, fsm_done;
   logic [RECW-1:0] rec_rd, rec_q;
   logic [RBW-1:0]  rd_beat;
   logic [WBW-1:0]  wr_beat;
   logic [RBW:0]    n_rd;
   logic [WBW:0]    n_wb;
   logic [LATW-1:0] n_lat;
   logic [NSRC-1:0] src_en;

   assign busy  = (phase != PH_IDLE);
   assign start = trig & ~busy;

   cix_cfg_mem #(.DEPTH(DEPTH), .RECW(RECW)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .lock(busy),
      .waddr(cfg_addr), .wdata(cfg_wdata), .raddr(trig_sel), .rdata(rec_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_q <= '0;
         err   <= 1'b0;
      end else begin
         err <= trig & busy;
         if (start) rec_q <= rec_rd;
      end
   end

   // beat and latency counts derived from the latched record
   always_comb begin
      int t;
      t = (int'(rec_q[SCW-1:0]) + RP - 1) / RP;
      if (t < 1) t = 1;
      if (t > NRB) t = NRB;
      n_rd = (RBW+1)'(t);
      n_lat = rec_q[OFF_LAT +: LATW];
      if (n_lat == '0) n_lat = LATW'(1);
      else if (n_lat > LATW'(MAXLAT)) n_lat = LATW'(MAXLAT);
      n_wb = (WBW+1)'(1);
      for (int j = 0; j < NDST; j++) begin
         if (rec_q[OFF_VLD + j]) n_wb = (WBW+1)'(j / WP + 1);
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src_en
      assign src_en[i] = (SCW'(i) < rec_q[SCW-1:0]);
   end

   cix_seq_fsm #(.RBW(RBW), .WBW(WBW), .LATW(LATW), .MAXLAT(MAXLAT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .n_rd(n_rd), .n_lat(n_lat),
      .n_wb(n_wb), .phase(phase), .rd_beat(rd_beat), .wr_beat(wr_beat),
      .done(fsm_done)
   );

   cix_port_map #(.NPORT(RP), .NIDX(NSRC), .RW(RW), .BW(RBW)) u_rd_map (
      .active(phase == PH_READ), .beat(rd_beat), .idx_en(src_en),
      .idx_reg(rec_q[OFF_SRC +: NSRC*RW]), .port_en(rd_en), .port_reg(rd_addr)
   );

   cix_port_map #(.NPORT(WP), .NIDX(NDST), .RW(RW), .BW(WBW)) u_wr_map (
      .active(phase == PH_WB), .beat(wr_beat), .idx_en(rec_q[OFF_VLD +: NDST]),
      .idx_reg(rec_q[OFF_DST +: NDST*RW]), .port_en(wr_en), .port_reg(wr_addr)
   );

   assign stall   = busy;
   assign res_sel = busy;
   assign mcfg    = rec_q[OFF_OP +: CFGW];
   assign done    = fsm_done;

   // R9
   ignored_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy) |=> $stable(mcfg));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !stall);
   // R4
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((|rd_en) && (|wr_en)));
   // R7
   port_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|rd_en) || (|wr_en)) |-> res_sel);
endmodule

// File: tb/sim_cix_sequencer.sv
`timescale 1ns/100ps
module sim_cix_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [98:0] cfg_wdata = '0;
   logic        trig = 1'b0;
   logic [3:0]  trig_sel = '0;
   logic        stall, res_sel, done, err;
   logic [3:0]  rd_en, wr_en;
   logic [19:0] rd_addr, wr_addr;
   logic [15:0] mcfg;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   cix_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .trig(trig), .trig_sel(trig_sel), .stall(stall),
      .res_sel(res_sel), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
      .wr_addr(wr_addr), .mcfg(mcfg), .done(done), .err(err)
   );

   // {entry, source count, latency field, destination valid bits}
   localparam logic [16:0] VEC [8] = '{
      {4'd0, 4'd8, 3'd5, 6'h3F}, {4'd1, 4'd1, 3'd1, 6'h01},
      {4'd2, 4'd4, 3'd3, 6'h0F}, {4'd3, 4'd5, 3'd2, 6'h10},
      {4'd4, 4'd0, 3'd0, 6'h00}, {4'd5, 4'd8, 3'd7, 6'h20},
      {4'd6, 4'd3, 3'd4, 6'h0A}, {4'd7, 4'd6, 3'd1, 6'h30}
   };

   function automatic logic [4:0] src_reg(int e, int i);
      return 5'((e * 7 + i * 3 + 1) % 32);
   endfunction
   function automatic logic [4:0] dst_reg(int e, int j);
      return 5'((e * 5 + j * 11 + 2) % 32);
   endfunction
   function automatic logic [15:0] op_of(int e);
      return 16'(16'hA000 + e * 17);
   endfunction

   function automatic logic [98:0] mk_rec(int e, logic [3:0] cnt, logic [2:0] lat,
                                          logic [5:0] vld);
      logic [98:0] r;
      r = '0;
      r[3:0] = cnt;
      for (int i = 0; i < 8; i++) r[4 + 5*i +: 5] = src_reg(e, i);
      r[49:44] = vld;
      for (int j = 0; j < 6; j++) r[50 + 5*j +: 5] = dst_reg(e, j);
      r[82:80] = lat;
      r[98:83] = op_of(e);
      return r;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_rec(int e, logic [3:0] cnt, logic [2:0] lat, logic [5:0] vld);
      cfg_we = 1'b1; cfg_addr = 4'(e); cfg_wdata = mk_rec(e, cnt, lat, vld);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // starts at a negedge with the design idle, ends at the negedge of the done cycle
   task automatic run(int e, logic [3:0] cnt, logic [2:0] lat, logic [5:0] vld, bit inject);
      int nr, nl, nw, tot;
      nr = (int'(cnt) + 3) / 4; if (nr < 1) nr = 1;
      nl = int'(lat); if (nl < 1) nl = 1; if (nl > 5) nl = 5;
      nw = 1;
      for (int j = 0; j < 6; j++) if (vld[j]) nw = j / 4 + 1;
      tot = nr + nl + nw;
      trig = 1'b1; trig_sel = 4'(e);
      @(negedge clk);
      trig = 1'b0;
      for (int k = 0; k < tot; k++) begin
         logic [3:0] xr, xw;
         xr = '0; xw = '0;
         chk(stall === 1'b1, "R3 stall during run", 32'(stall), 1);
         chk(res_sel === 1'b1, "R7 res_sel during run", 32'(res_sel), 1);
         chk(mcfg === op_of(e), "R10 mcfg", 32'(mcfg), 32'(op_of(e)));
         chk(err === (inject && k == 2), "R9 err pulse", 32'(err), 32'(inject && k == 2));
         for (int p = 0; p < 4; p++) begin
            if (k < nr && (k*4 + p) < int'(cnt)) begin
               xr[p] = 1'b1;
               chk(rd_addr[5*p +: 5] === src_reg(e, k*4 + p), "R4 read index",
                   32'(rd_addr[5*p +: 5]), 32'(src_reg(e, k*4 + p)));
            end
            if (k >= nr + nl && ((k-nr-nl)*4 + p) < 6 && vld[(k-nr-nl)*4 + p]) begin
               xw[p] = 1'b1;
               chk(wr_addr[5*p +: 5] === dst_reg(e, (k-nr-nl)*4 + p), "R6 write index",
                   32'(wr_addr[5*p +: 5]), 32'(dst_reg(e, (k-nr-nl)*4 + p)));
            end
         end
         chk(rd_en === xr, "R4/R5 read enables", 32'(rd_en), 32'(xr));
         chk(wr_en === xw, "R6/R5 write enables", 32'(wr_en), 32'(xw));
         chk(done === 1'b0, "R8 no early done", 32'(done), 0);
         if (inject && k == 1) begin
            trig = 1'b1; trig_sel = 4'(e + 1);
            cfg_we = 1'b1; cfg_addr = 4'(e); cfg_wdata = ~mk_rec(e, cnt, lat, vld);
         end else begin
            trig = 1'b0; cfg_we = 1'b0;
         end
         @(negedge clk);
      end
      chk(done === 1'b1, "R8 done after last write", 32'(done), 1);
      chk(stall === 1'b0, "R3 stall released", 32'(stall), 0);
      chk(res_sel === 1'b0, "R7 select returns", 32'(res_sel), 0);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk({stall, res_sel, done, err, rd_en, wr_en} === '0, "R1 in reset",
          32'({stall, res_sel, done, err, rd_en, wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({stall, res_sel, done, err, rd_en, wr_en} === '0, "R1 after reset",
          32'({stall, res_sel, done, err, rd_en, wr_en}), 0);

      // R2 program the table while idle
      for (int v = 0; v < 8; v++)
         wr_rec(int'(VEC[v][16:13]), VEC[v][12:9], VEC[v][8:6], VEC[v][5:0]);

      // table walk
      for (int v = 0; v < 8; v++) begin
         run(int'(VEC[v][16:13]), VEC[v][12:9], VEC[v][8:6], VEC[v][5:0], 1'b0);
         @(negedge clk);
         chk(done === 1'b0, "R8 done one cycle", 32'(done), 0);
      end

      // R9 and R2: collision in the middle of a run on entry 0
      run(0, 4'd8, 3'd5, 6'h3F, 1'b1);
      @(negedge clk);
      // R2: entry 0 must still hold its original record
      run(0, 4'd8, 3'd5, 6'h3F, 1'b0);
      // R8: start again in the done cycle
      run(2, 4'd4, 3'd3, 6'h0F, 1'b0);
      run(1, 4'd1, 3'd1, 6'h01, 1'b0);
      @(negedge clk);
      chk(done === 1'b0 && stall === 1'b0, "R8 idle after back-to-back",
          32'({done, stall}), 0);

      // R2: rewrite entry 3 while idle, then run the new contents
      wr_rec(3, 4'd2, 3'd1, 6'h02);
      run(3, 4'd2, 3'd1, 6'h02, 1'b0);
      @(negedge clk);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule